// File: doc/BRIEF.md
# Rotating Multi-Scheduler Dual-Issue Stage

This block is the issue stage of a GPU shader core with several warp schedulers. In every cycle it walks all schedulers once. The walk starts at a rotating priority pointer, which moves forward by one scheduler after every cycle. Each scheduler presents the warp it has already selected. For that warp it presents a waiting flag, a buffer-empty flag, a flag that says a second instruction is buffered, and the execution-unit kind of the first and second buffered instructions. The stage issues zero, one or two instructions from that warp.

Each execution-unit kind has a number of free dispatch slots this cycle, given on `unit_free`. A scheduler earlier in the walk takes slots before the later ones do. A slot it takes is gone for the rest of the cycle. Issue from a warp halts at the first instruction that cannot go. One configuration input allows a second issue per warp. Another requires that the second instruction use a different unit kind from the first. A counter records the cycles in which at least one scheduler dual-issued.

Issue strobes and unit selects are combinational outputs of the current inputs and the pointer. The pointer and the counter are registers.

Top module: `dual_issue_stage`

## Requirements
- R1: A synchronous active-high `rst` sets the priority pointer to scheduler 0 and `dual_cycles` to 0. In the first cycle after reset, scheduler 0 is visited first.
- R2: Scheduler (p + i) mod N is visited in position i of the walk, where p is the pointer. The pointer advances by one, modulo N, on every clock edge without reset, whether or not anything issues. On the k-th cycle after reset, scheduler k mod N is visited first.
- R3: The first instruction of scheduler s issues (`issue_first[s]`=1) only if all of these hold: the warp is not waiting, the buffer is not empty, the head kind is not none, and the head kind has a free slot left after the earlier schedulers in the walk.
- R4: The second instruction issues only if all of these hold: the first one issued, `cfg_dual_en`=1, `ibuf_has_two[s]`=1, the second kind is not none, and that kind still has a free slot after the first instruction took its slot.
- R5: When the first instruction of a warp fails to issue, the second never issues, even if the second instruction's own conditions are met.
- R6: When `cfg_diff_unit`=1, a second instruction whose kind equals the first instruction's kind does not issue. When `cfg_diff_unit`=0, two instructions of the same kind may both issue if that kind has two slots.
- R7: Across all schedulers, the number of instructions dispatched to a unit kind in one cycle never exceeds that kind's free-slot count. The field of kind k in `unit_free` is bits [k*FREE_W-1 -: FREE_W], for k = 1..3.
- R8: `dual_cycles` increases by exactly one after each cycle in which any `issue_second` bit is set, and it wraps at 2^CNT_W.
- R9: Unit kinds are encoded on 2 bits as none=0, SP=1, SFU=2, MEM=3. Field s of `first_unit` and `second_unit` (bits [2s+1:2s]) carries the kind of the issued instruction, or 0 when that instruction did not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual_en | input | 1 | 1 allows two issues per warp per cycle, 0 allows one |
| cfg_diff_unit | input | 1 | 1 requires the second issue to use a different unit kind |
| warp_wait | input | NUM_SCHED | Selected warp is waiting, per scheduler |
| ibuf_empty | input | NUM_SCHED | Instruction buffer empty, per scheduler |
| ibuf_has_two | input | NUM_SCHED | Buffer holds a second instruction, per scheduler |
| head_unit | input | 2*NUM_SCHED | Unit kind of the head instruction, per scheduler |
| next_unit | input | 2*NUM_SCHED | Unit kind of the second instruction, per scheduler |
| unit_free | input | 3*FREE_W | Free dispatch slots for SP, SFU and MEM |
| issue_first | output | NUM_SCHED | First instruction issued, per scheduler |
| issue_second | output | NUM_SCHED | Second instruction issued, per scheduler |
| first_unit | output | 2*NUM_SCHED | Dispatch unit of the first issue, per scheduler |
| second_unit | output | 2*NUM_SCHED | Dispatch unit of the second issue, per scheduler |
| dual_cycles | output | CNT_W | Count of cycles with at least one dual issue |

## Verification
A long random run draws per-cycle waiting, empty and second-entry flags, unit kinds that include none, and slot counts from zero to three. It also toggles both configuration inputs. Together these stress the slot handoff along the walk and the halt-on-failure rule under many pointer positions.

Directed cases add four checks. A single scarce SP slot that every scheduler wants shows whether the pointer rotates or stays fixed. A blocked head over an issuable second instruction separates the halt rule from independent per-instruction checks. A same-kind pair with two free slots, tried with the distinct-unit bit set and cleared, shows whether that bit is honoured. With the dual-issue enable off, the test shows that second issues and counter increments both stop.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

   localparam int KIND_W    = 2;
   localparam int NUM_KINDS = 3;

   typedef enum logic [KIND_W-1:0] {
      UK_NONE = 2'd0,
      UK_SP   = 2'd1,
      UK_SFU  = 2'd2,
      UK_MEM  = 2'd3
   } unit_kind_e;

endpackage

// File: rtl/issue_rot_ptr.sv
module issue_rot_ptr #(
   parameter int NUM_SCHED = 4,
   localparam int PTR_W    = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SCHED - 1);

   always_ff @(posedge clk) begin
      if (rst)              ptr <= '0;
      else if (ptr == LAST) ptr <= '0;
      else                  ptr <= ptr + 1'b1;
   end

   a_r1_ptr_reset: assert property (@(posedge clk) rst |=> ptr == '0);

   a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

   a_r2_ptr_range: assert property (@(posedge clk) disable iff (rst)
      int'(ptr) < NUM_SCHED);

endmodule

// File: rtl/issue_slot.sv
module issue_slot
   import dual_issue_pkg::*;
#(
   parameter int FREE_W = 2,
   localparam int FV_W  = NUM_KINDS * FREE_W
) (
   input  logic            en_two,
   input  logic            diff_only,
   input  logic            warp_waiting,
   input  logic            buf_empty,
   input  logic            buf_two,
   input  unit_kind_e      kind_a,
   input  unit_kind_e      kind_b,
   input  logic [FV_W-1:0] free_in,
   output logic [FV_W-1:0] free_out,
   output logic            go_a,
   output logic            go_b
);

   function automatic logic has_room(input logic [FV_W-1:0] v, input unit_kind_e k);
      if (k == UK_NONE) return 1'b0;
      return v[(int'(k) - 1) * FREE_W +: FREE_W] != '0;
   endfunction

   function automatic logic [FV_W-1:0] take_one(input logic [FV_W-1:0] v,
                                                input unit_kind_e k);
      logic [FV_W-1:0] r;
      r = v;
      if (k != UK_NONE)
         r[(int'(k) - 1) * FREE_W +: FREE_W] = v[(int'(k) - 1) * FREE_W +: FREE_W] - 1'b1;
      return r;
   endfunction

   logic [FV_W-1:0] after_a;
   logic            clash;

   always_comb begin
      go_a    = !warp_waiting && !buf_empty && has_room(free_in, kind_a);
      after_a = go_a ? take_one(free_in, kind_a) : free_in;
      clash   = diff_only && (kind_b == kind_a);
      go_b    = go_a && en_two && buf_two && !clash && has_room(after_a, kind_b);
      free_out = go_b ? take_one(after_a, kind_b) : after_a;
   end

endmodule

// File: rtl/dual_tally.sv
module dual_tally #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk) begin
      if (rst)      count <= '0;
      else if (hit) count <= count + 1'b1;
   end

   a_r1_cnt_reset: assert property (@(posedge clk) rst |=> count == '0);

   a_r8_cnt_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> count == $past(count) + CNT_W'($past(hit)));

endmodule

// File: rtl/dual_issue_stage.sv
module dual_issue_stage
   import dual_issue_pkg::*;
#(
   parameter int NUM_SCHED = 4,
   parameter int FREE_W    = 2,
   parameter int CNT_W     = 16,
   localparam int PTR_W    = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
   localparam int FV_W     = NUM_KINDS * FREE_W,
   localparam int SEL_W    = KIND_W * NUM_SCHED
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cfg_dual_en,
   input  logic                 cfg_diff_unit,
   input  logic [NUM_SCHED-1:0] warp_wait,
   input  logic [NUM_SCHED-1:0] ibuf_empty,
   input  logic [NUM_SCHED-1:0] ibuf_has_two,
   input  logic [SEL_W-1:0]     head_unit,
   input  logic [SEL_W-1:0]     next_unit,
   input  logic [FV_W-1:0]      unit_free,
   output logic [NUM_SCHED-1:0] issue_first,
   output logic [NUM_SCHED-1:0] issue_second,
   output logic [SEL_W-1:0]     first_unit,
   output logic [SEL_W-1:0]     second_unit,
   output logic [CNT_W-1:0]     dual_cycles
);

   if (NUM_SCHED < 2) begin : g_bad_sched
      $error("dual_issue_stage: NUM_SCHED must be at least 2");
   end
   if (FREE_W < 1) begin : g_bad_free
      $error("dual_issue_stage: FREE_W must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("dual_issue_stage: CNT_W must be at least 2");
   end

   logic [PTR_W-1:0] prio;
   logic [PTR_W-1:0] at_pos   [NUM_SCHED];
   logic [FV_W-1:0]  chain    [NUM_SCHED+1];
   logic             pos_go_a [NUM_SCHED];
   logic             pos_go_b [NUM_SCHED];
   unit_kind_e       pos_ka   [NUM_SCHED];
   unit_kind_e       pos_kb   [NUM_SCHED];

   issue_rot_ptr #(.NUM_SCHED(NUM_SCHED)) u_ptr (
      .clk (clk),
      .rst (rst),
      .ptr (prio)
   );

   always_comb begin
      for (int i = 0; i < NUM_SCHED; i++) begin
         int t;
         t = int'(prio) + i;
         if (t >= NUM_SCHED) t = t - NUM_SCHED;
         at_pos[i] = PTR_W'(t);
      end
   end

   assign chain[0] = unit_free;

   for (genvar i = 0; i < NUM_SCHED; i++) begin : g_pos
      logic       p_wait, p_empty, p_two;
      unit_kind_e p_ka, p_kb;

      always_comb begin
         p_wait  = warp_wait[at_pos[i]];
         p_empty = ibuf_empty[at_pos[i]];
         p_two   = ibuf_has_two[at_pos[i]];
         p_ka    = unit_kind_e'(head_unit[int'(at_pos[i]) * KIND_W +: KIND_W]);
         p_kb    = unit_kind_e'(next_unit[int'(at_pos[i]) * KIND_W +: KIND_W]);
      end

      issue_slot #(.FREE_W(FREE_W)) u_slot (
         .en_two       (cfg_dual_en),
         .diff_only    (cfg_diff_unit),
         .warp_waiting (p_wait),
         .buf_empty    (p_empty),
         .buf_two      (p_two),
         .kind_a       (p_ka),
         .kind_b       (p_kb),
         .free_in      (chain[i]),
         .free_out     (chain[i+1]),
         .go_a         (pos_go_a[i]),
         .go_b         (pos_go_b[i])
      );

      assign pos_ka[i] = p_ka;
      assign pos_kb[i] = p_kb;
   end

   always_comb begin
      issue_first  = '0;
      issue_second = '0;
      first_unit   = '0;
      second_unit  = '0;
      for (int s = 0; s < NUM_SCHED; s++) begin
         for (int i = 0; i < NUM_SCHED; i++) begin
            if (int'(at_pos[i]) == s) begin
               issue_first[s]  = pos_go_a[i];
               issue_second[s] = pos_go_b[i];
               first_unit[s*KIND_W +: KIND_W]  = pos_go_a[i] ? pos_ka[i] : UK_NONE;
               second_unit[s*KIND_W +: KIND_W] = pos_go_b[i] ? pos_kb[i] : UK_NONE;
            end
         end
      end
   end

   dual_tally #(.CNT_W(CNT_W)) u_tally (
      .clk   (clk),
      .rst   (rst),
      .hit   (|issue_second),
      .count (dual_cycles)
   );

   // Checks on the assembled outputs
   logic [PTR_W+1:0] claim_cnt [NUM_KINDS];

   always_comb begin
      for (int k = 0; k < NUM_KINDS; k++) begin
         claim_cnt[k] = '0;
         for (int s = 0; s < NUM_SCHED; s++) begin
            if (issue_first[s] && int'(first_unit[s*KIND_W +: KIND_W]) == k + 1)
               claim_cnt[k] = claim_cnt[k] + 1'b1;
            if (issue_second[s] && int'(second_unit[s*KIND_W +: KIND_W]) == k + 1)
               claim_cnt[k] = claim_cnt[k] + 1'b1;
         end
      end
   end

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_unit_chk
      a_r7_slot_limit: assert property (@(posedge clk) disable iff (rst)
         int'(claim_cnt[k]) <= int'(unit_free[k*FREE_W +: FREE_W]));
   end

   for (genvar s = 0; s < NUM_SCHED; s++) begin : g_sched_chk
      a_r5_no_orphan_second: assert property (@(posedge clk) disable iff (rst)
         issue_second[s] |-> issue_first[s]);
      a_r3_first_needs_ready: assert property (@(posedge clk) disable iff (rst)
         issue_first[s] |-> (!warp_wait[s] && !ibuf_empty[s]));
      a_r4_second_needs_cfg: assert property (@(posedge clk) disable iff (rst)
         issue_second[s] |-> (cfg_dual_en && ibuf_has_two[s]));
      a_r6_distinct_units: assert property (@(posedge clk) disable iff (rst)
         (issue_second[s] && cfg_diff_unit) |->
            second_unit[s*KIND_W +: KIND_W] != first_unit[s*KIND_W +: KIND_W]);
      a_r9_idle_select: assert property (@(posedge clk) disable iff (rst)
         !issue_first[s] |-> first_unit[s*KIND_W +: KIND_W] == UK_NONE);
   end

endmodule

// File: tb/tb_dual_issue_stage.sv
`timescale 1ns/1ps
module tb_dual_issue_stage;

   localparam int N      = 4;
   localparam int FREE_W = 2;
   localparam int CNT_W  = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_dual_en = 1'b0, cfg_diff_unit = 1'b0;
   logic [N-1:0] warp_wait = '0, ibuf_empty = '1, ibuf_has_two = '0;
   logic [2*N-1:0] head_unit = '0, next_unit = '0;
   logic [3*FREE_W-1:0] unit_free = '0;
   logic [N-1:0] issue_first, issue_second;
   logic [2*N-1:0] first_unit, second_unit;
   logic [CNT_W-1:0] dual_cycles;

   int checks = 0, errors = 0;
   int exp_prio = 0;
   int exp_cnt = 0;
   logic [N-1:0] e_first, e_second;
   logic [2*N-1:0] e_funit, e_sunit;
   logic e_dual;

   always #2.5 clk = ~clk;

   dual_issue_stage #(.NUM_SCHED(N), .FREE_W(FREE_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst(rst), .cfg_dual_en(cfg_dual_en), .cfg_diff_unit(cfg_diff_unit),
      .warp_wait(warp_wait), .ibuf_empty(ibuf_empty), .ibuf_has_two(ibuf_has_two),
      .head_unit(head_unit), .next_unit(next_unit), .unit_free(unit_free),
      .issue_first(issue_first), .issue_second(issue_second),
      .first_unit(first_unit), .second_unit(second_unit), .dual_cycles(dual_cycles));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic int fld(input logic [3*FREE_W-1:0] v, input int k);
      return int'(v[k*FREE_W +: FREE_W]);
   endfunction

   task automatic model();
      int avail[3];
      for (int k = 0; k < 3; k++) avail[k] = fld(unit_free, k);
      e_first = '0; e_second = '0; e_funit = '0; e_sunit = '0;
      for (int i = 0; i < N; i++) begin
         int s, a, b;
         logic oa, ob;
         s = (exp_prio + i) % N;
         a = int'(head_unit[2*s +: 2]);
         b = int'(next_unit[2*s +: 2]);
         oa = !warp_wait[s] && !ibuf_empty[s] && a != 0 && avail[(a == 0) ? 0 : a-1] > 0;
         if (oa) avail[a-1]--;
         ob = oa && cfg_dual_en && ibuf_has_two[s] && b != 0 &&
              !(cfg_diff_unit && b == a) && avail[(b == 0) ? 0 : b-1] > 0;
         if (ob) avail[b-1]--;
         e_first[s] = oa;
         e_second[s] = ob;
         if (oa) e_funit[2*s +: 2] = 2'(a);
         if (ob) e_sunit[2*s +: 2] = 2'(b);
      end
      e_dual = |e_second;
   endtask

   // Called right after driving inputs at a negedge
   task automatic settle();
      #1;
      model();
      check("R3 issue_first", 32'(issue_first), 32'(e_first));
      check("R4 issue_second", 32'(issue_second), 32'(e_second));
      check("R9 first_unit", 32'(first_unit), 32'(e_funit));
      check("R9 second_unit", 32'(second_unit), 32'(e_sunit));
      check("R8 dual_cycles", 32'(dual_cycles), 32'(exp_cnt));
   endtask

   task automatic advance();
      @(posedge clk);
      exp_prio = (exp_prio + 1) % N;
      if (e_dual) exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
      @(negedge clk);
   endtask

   task automatic all_ready(input logic [1:0] kind_a, input logic [1:0] kind_b);
      warp_wait = '0; ibuf_empty = '0; ibuf_has_two = '1;
      head_unit = {N{kind_a}}; next_unit = {N{kind_b}};
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      exp_prio = 0; exp_cnt = 0;

      // R1: reset state, scheduler 0 wins a single SP slot
      all_ready(2'd1, 2'd0);
      unit_free = {2'd0, 2'd0, 2'd1};
      settle();
      check("R1 dual_cycles after reset", 32'(dual_cycles), 0);
      check("R1 scheduler 0 first", 32'(issue_first), 32'b0001);
      advance();

      // R2: the lone slot rotates with the pointer
      for (int k = 1; k < 2 * N; k++) begin
         settle();
         check("R2 rotating winner", 32'(issue_first), 32'(1 << (k % N)));
         advance();
      end

      // R5: blocked head with an issuable second instruction
      all_ready(2'd1, 2'd2);
      cfg_dual_en = 1'b1; cfg_diff_unit = 1'b0;
      unit_free = {2'd0, 2'd3, 2'd0};
      settle();
      check("R5 no second after blocked head", 32'(issue_second), 0);
      advance();

      // R6: same-kind pair, two SP slots, one warp active
      all_ready(2'd1, 2'd1);
      warp_wait = 4'b1110 << 0;
      ibuf_empty = '0;
      unit_free = {2'd0, 2'd0, 2'd2};
      cfg_diff_unit = 1'b1;
      // only scheduler 0 is not waiting
      settle();
      check("R6 same kind blocked", 32'(issue_second), 0);
      advance();
      cfg_diff_unit = 1'b0;
      settle();
      check("R6 same kind allowed", 32'(issue_second), 32'b0001);
      advance();

      // R7: four MEM requests, two slots
      all_ready(2'd3, 2'd0);
      unit_free = {2'd2, 2'd0, 2'd0};
      settle();
      check("R7 slot count", 32'($countones(issue_first)), 2);
      advance();

      // R4: dual disabled
      all_ready(2'd1, 2'd2);
      cfg_dual_en = 1'b0;
      unit_free = {2'd3, 2'd3, 2'd3};
      settle();
      check("R4 dual disabled", 32'(issue_second), 0);
      advance();

      // Random phase
      for (int c = 0; c < 4000; c++) begin
         for (int s = 0; s < N; s++) begin
            warp_wait[s]    = ($urandom_range(0, 4) == 0);
            ibuf_empty[s]   = ($urandom_range(0, 4) == 0);
            ibuf_has_two[s] = ($urandom_range(0, 3) != 0);
            head_unit[2*s +: 2] = 2'($urandom_range(0, 3));
            next_unit[2*s +: 2] = 2'($urandom_range(0, 3));
         end
         unit_free = 6'($urandom_range(0, 63));
         cfg_dual_en   = ($urandom_range(0, 3) != 0);
         cfg_diff_unit = $urandom_range(0, 1) == 1;
         settle();
         advance();
      end
      settle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule